// File: doc/BRIEF.md
# Recurrent Integrate-and-Fire Neurocontroller

This block evaluates a small, fully recurrent spiking network that steers a simple agent. The network has ten neurons that produce one-bit outputs. Four of them drive the motor bits. Five sensor bits feed every network neuron. Each network neuron also hears every network neuron, itself included, through the spike vector of the previous control step. Each neuron keeps a signed membrane voltage. At every step, the held voltage is first scaled by that neuron's leak fraction. The weighted activations of all fifteen sources are then added to it. When the result is strictly greater than the neuron's threshold, the neuron spikes for that step and its voltage drops back to zero.

A control step begins with a start pulse and ends with a one-cycle done pulse. The step is worked through serially by a state machine with one multiply and one saturating adder. The machine goes through ST_IDLE, then ST_LEAK, ST_ACCUM and ST_FIRE once for each neuron, and finishes with ST_COMMIT and ST_REPORT. Its transitions are:
- start-accept: ST_IDLE to ST_LEAK.
- sum: ST_LEAK to ST_ACCUM.
- source-advance: ST_ACCUM to itself.
- last-source: ST_ACCUM to ST_FIRE.
- next-neuron: ST_FIRE to ST_LEAK.
- last-neuron: ST_FIRE to ST_COMMIT.
- publish: ST_COMMIT to ST_REPORT.
- release: ST_REPORT to ST_IDLE.

Leak factors, thresholds and the weight matrix are loaded through a register write port. That port only works while the machine is idle.

Top module: `ifn_neurocontroller`

## Requirements
- R1: Each neuron has fifteen sources, selected by wr_src: indices 0 to 4 are sensor bits 0 to 4, and indices 5 to 14 are network neurons 0 to 9. A source contributes its 8-bit signed weight only when its activation bit is 1.
- R2: At the start of its update, a neuron's held voltage v becomes floor(v * leak / 256). Here leak is the neuron's 8-bit unsigned factor.
- R3: A neuron spikes for the step only when its summed voltage is strictly greater than its 16-bit signed threshold. Equality does not fire.
- R4: A neuron that spikes stores voltage zero. It can spike again on the very next step, because there is no refractory period.
- R5: Each weight addition saturates to the range -32768 to 32767 instead of wrapping.
- R6: All neurons in a step use the spike vector from the previous step. The sensor bits are sampled in the cycle where start is accepted, and later sensor changes do not affect that step.
- R7: A done pulse lasts exactly one cycle and comes exactly 171 cycles after the accepting start edge, that is ten times seventeen plus one. The spike vector changes only in the done cycle.
- R8: motor[0] carries neuron 0 (forward), motor[1] neuron 1 (turn left), motor[2] neuron 2 (turn right) and motor[3] neuron 3 (mouth state), always equal to spikes[3:0].
- R9: The wr_kind field selects what a write updates. Kind 0 writes a weight from wr_data[7:0], addressed by wr_dst and wr_src. Kind 1 writes a leak from wr_data[7:0], addressed by wr_dst. Kind 2 writes a threshold from wr_data[15:0], addressed by wr_dst. Kind 3 changes nothing. Writes made while a step is in progress are ignored.
- R10: A synchronous reset clears every voltage, spike bit, weight, leak and threshold to zero, and holds done low.
- R11: A start pulse while a step is in progress is ignored. It neither restarts the step nor produces an extra done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a control step when idle |
| sensors | input | 5 | Sensor bits, sampled on start |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Write target: 0 weight, 1 leak, 2 threshold, 3 none |
| wr_dst | input | 4 | Destination neuron index |
| wr_src | input | 4 | Source index for weight writes |
| wr_data | input | 16 | Write value |
| motor | output | 4 | Motor spike bits (forward, left, right, mouth) |
| spikes | output | 10 | Spike vector of the last completed step |
| done | output | 1 | One-cycle step-complete pulse |

## Verification
The assertions assume that reset is applied from the first clock edge. They also assume that start is the only thing that opens a step. Under that assumption, a start that comes while a step is already running must leave the done timing untouched. The stimulus drives every input on the falling clock edge and holds reset high from time zero. It deliberately puts starts, register writes and sensor changes inside a running step. Those requests must be dropped, so the checker's own count of the step length stays valid.

// File: rtl/ifn_pkg.sv
package ifn_pkg;

    localparam int VOLT_W = 16;
    localparam int WGT_W  = 8;
    localparam int LEAK_W = 8;
    localparam int PROD_W = VOLT_W + LEAK_W + 1;

    localparam logic signed [VOLT_W-1:0] VOLT_MAX = {1'b0, {(VOLT_W-1){1'b1}}};
    localparam logic signed [VOLT_W-1:0] VOLT_MIN = {1'b1, {(VOLT_W-1){1'b0}}};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAK,
        ST_ACCUM,
        ST_FIRE,
        ST_COMMIT,
        ST_REPORT
    } step_state_t;

    typedef enum logic [1:0] {
        WK_WEIGHT = 2'd0,
        WK_LEAK   = 2'd1,
        WK_THRESH = 2'd2,
        WK_NONE   = 2'd3
    } wr_kind_t;

    // Held voltage scaled by an unsigned fraction of 256, rounded toward minus infinity.
    function automatic logic signed [VOLT_W-1:0] leak_scale(
        input logic signed [VOLT_W-1:0] v,
        input logic        [LEAK_W-1:0] f
    );
        logic signed [PROD_W-1:0] p;
        p = PROD_W'(v) * PROD_W'($signed({1'b0, f}));
        return p[VOLT_W+LEAK_W-1:LEAK_W];
    endfunction

    // Add a signed weight, clamping at the voltage range limits.
    function automatic logic signed [VOLT_W-1:0] sat_add(
        input logic signed [VOLT_W-1:0] a,
        input logic signed [WGT_W-1:0]  w
    );
        logic signed [VOLT_W:0] s;
        s = {a[VOLT_W-1], a} + {{(VOLT_W+1-WGT_W){w[WGT_W-1]}}, w};
        if (s[VOLT_W] != s[VOLT_W-1])
            return s[VOLT_W] ? VOLT_MIN : VOLT_MAX;
        return s[VOLT_W-1:0];
    endfunction

endpackage

// File: rtl/ifn_param_store.sv
module ifn_param_store
    import ifn_pkg::*;
#(
    parameter int N_NET  = 10,
    parameter int N_SRC  = 15,
    parameter int NIDX_W = $clog2(N_NET),
    parameter int SIDX_W = $clog2(N_SRC)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic                      busy,
    input  logic [1:0]                wr_kind,
    input  logic [NIDX_W-1:0]         wr_dst,
    input  logic [SIDX_W-1:0]         wr_src,
    input  logic [VOLT_W-1:0]         wr_data,
    input  logic [NIDX_W-1:0]         rd_nrn,
    input  logic [SIDX_W-1:0]         rd_src,
    output logic signed [WGT_W-1:0]   rd_weight,
    output logic [LEAK_W-1:0]         rd_leak,
    output logic signed [VOLT_W-1:0]  rd_thresh
);

    logic signed [WGT_W-1:0]  wmem  [N_NET][N_SRC];
    logic [LEAK_W-1:0]        lmem  [N_NET];
    logic signed [VOLT_W-1:0] tmem  [N_NET];

    logic dst_ok, src_ok, accept;
    assign dst_ok = int'(wr_dst) < N_NET;
    assign src_ok = int'(wr_src) < N_SRC;
    assign accept = wr_en && !busy && dst_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < N_NET; n++) begin
                lmem[n] <= '0;
                tmem[n] <= '0;
                for (int s = 0; s < N_SRC; s++)
                    wmem[n][s] <= '0;
            end
        end else if (accept) begin
            unique case (wr_kind_t'(wr_kind))
                WK_WEIGHT: if (src_ok) wmem[wr_dst][wr_src] <= wr_data[WGT_W-1:0];
                WK_LEAK:   lmem[wr_dst] <= wr_data[LEAK_W-1:0];
                WK_THRESH: tmem[wr_dst] <= wr_data;
                WK_NONE:   ;
            endcase
        end
    end

    assign rd_weight = wmem[rd_nrn][rd_src];
    assign rd_leak   = lmem[rd_nrn];
    assign rd_thresh = tmem[rd_nrn];

endmodule

// File: rtl/ifn_step_fsm.sv
module ifn_step_fsm
    import ifn_pkg::*;
#(
    parameter int N_NET  = 10,
    parameter int N_SRC  = 15,
    parameter int NIDX_W = $clog2(N_NET),
    parameter int SIDX_W = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [NIDX_W-1:0] nrn_idx,
    output logic [SIDX_W-1:0] src_idx,
    output logic              accept,
    output logic              ld_leak,
    output logic              add_en,
    output logic              fire_en,
    output logic              commit,
    output logic              done,
    output logic              busy
);

    localparam logic [NIDX_W-1:0] LAST_NRN = NIDX_W'(N_NET - 1);
    localparam logic [SIDX_W-1:0] LAST_SRC = SIDX_W'(N_SRC - 1);

    step_state_t       state_q, state_d;
    logic [NIDX_W-1:0] nrn_q, nrn_d;
    logic [SIDX_W-1:0] src_q, src_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            nrn_q   <= '0;
            src_q   <= '0;
        end else begin
            state_q <= state_d;
            nrn_q   <= nrn_d;
            src_q   <= src_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        nrn_d   = nrn_q;
        src_d   = src_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_LEAK;
                    nrn_d   = '0;
                end
            end
            ST_LEAK: begin
                state_d = ST_ACCUM;
                src_d   = '0;
            end
            ST_ACCUM: begin
                if (src_q == LAST_SRC)
                    state_d = ST_FIRE;
                else
                    src_d = src_q + SIDX_W'(1);
            end
            ST_FIRE: begin
                if (nrn_q == LAST_NRN) begin
                    state_d = ST_COMMIT;
                end else begin
                    state_d = ST_LEAK;
                    nrn_d   = nrn_q + NIDX_W'(1);
                end
            end
            ST_COMMIT: state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        accept  = 1'b0;
        ld_leak = 1'b0;
        add_en  = 1'b0;
        fire_en = 1'b0;
        commit  = 1'b0;
        done    = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            ST_LEAK:   ld_leak = 1'b1;
            ST_ACCUM:  add_en  = 1'b1;
            ST_FIRE:   fire_en = 1'b1;
            ST_COMMIT: commit  = 1'b1;
            ST_REPORT: done    = 1'b1;
            default:   busy    = 1'b1;
        endcase
    end

    assign nrn_idx = nrn_q;
    assign src_idx = src_q;

endmodule

// File: rtl/ifn_membrane.sv
module ifn_membrane
    import ifn_pkg::*;
#(
    parameter int N_NET  = 10,
    parameter int N_SENS = 5,
    parameter int N_SRC  = N_NET + N_SENS,
    parameter int NIDX_W = $clog2(N_NET),
    parameter int SIDX_W = $clog2(N_SRC)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     accept,
    input  logic                     ld_leak,
    input  logic                     add_en,
    input  logic                     fire_en,
    input  logic                     commit,
    input  logic [N_SENS-1:0]        sensors,
    input  logic [NIDX_W-1:0]        nrn_idx,
    input  logic [SIDX_W-1:0]        src_idx,
    input  logic signed [WGT_W-1:0]  weight,
    input  logic [LEAK_W-1:0]        leak,
    input  logic signed [VOLT_W-1:0] thresh,
    output logic [N_NET-1:0]         act
);

    logic signed [VOLT_W-1:0] volt [N_NET];
    logic signed [VOLT_W-1:0] acc_q;
    logic [N_SENS-1:0]        sens_q;
    logic [N_NET-1:0]         nxt_q;
    logic [N_NET-1:0]         act_q;
    logic [N_SRC-1:0]         src_vec;
    logic                     src_on;
    logic                     above;

    // Sources: sensor bits low, previous-step spikes above them
    assign src_vec = {act_q, sens_q};
    assign src_on  = src_vec[src_idx];
    assign above   = acc_q > thresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < N_NET; n++)
                volt[n] <= '0;
            acc_q  <= '0;
            sens_q <= '0;
            nxt_q  <= '0;
            act_q  <= '0;
        end else begin
            if (accept)
                sens_q <= sensors;
            if (ld_leak)
                acc_q <= leak_scale(volt[nrn_idx], leak);
            if (add_en && src_on)
                acc_q <= sat_add(acc_q, weight);
            if (fire_en) begin
                nxt_q[nrn_idx] <= above;
                volt[nrn_idx]  <= above ? '0 : acc_q;
            end
            if (commit)
                act_q <= nxt_q;
        end
    end

    assign act = act_q;

endmodule

// File: rtl/ifn_neurocontroller.sv
module ifn_neurocontroller
    import ifn_pkg::*;
#(
    parameter int N_NET   = 10,
    parameter int N_SENS  = 5,
    parameter int N_MOTOR = 4,
    parameter int N_SRC   = N_NET + N_SENS,
    parameter int NIDX_W  = $clog2(N_NET),
    parameter int SIDX_W  = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [N_SENS-1:0] sensors,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [NIDX_W-1:0] wr_dst,
    input  logic [SIDX_W-1:0] wr_src,
    input  logic [VOLT_W-1:0] wr_data,
    output logic [N_MOTOR-1:0] motor,
    output logic [N_NET-1:0]  spikes,
    output logic              done
);

    logic [NIDX_W-1:0]        nrn_idx;
    logic [SIDX_W-1:0]        src_idx;
    logic                     accept, ld_leak, add_en, fire_en, commit, busy;
    logic signed [WGT_W-1:0]  weight;
    logic [LEAK_W-1:0]        leak;
    logic signed [VOLT_W-1:0] thresh;
    logic [N_NET-1:0]         act;

    ifn_step_fsm #(
        .N_NET(N_NET), .N_SRC(N_SRC), .NIDX_W(NIDX_W), .SIDX_W(SIDX_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .start(start),
        .nrn_idx(nrn_idx), .src_idx(src_idx),
        .accept(accept), .ld_leak(ld_leak), .add_en(add_en),
        .fire_en(fire_en), .commit(commit), .done(done), .busy(busy)
    );

    ifn_param_store #(
        .N_NET(N_NET), .N_SRC(N_SRC), .NIDX_W(NIDX_W), .SIDX_W(SIDX_W)
    ) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .busy(busy),
        .wr_kind(wr_kind), .wr_dst(wr_dst), .wr_src(wr_src), .wr_data(wr_data),
        .rd_nrn(nrn_idx), .rd_src(src_idx),
        .rd_weight(weight), .rd_leak(leak), .rd_thresh(thresh)
    );

    ifn_membrane #(
        .N_NET(N_NET), .N_SENS(N_SENS), .N_SRC(N_SRC), .NIDX_W(NIDX_W), .SIDX_W(SIDX_W)
    ) u_mem (
        .clk(clk), .rst(rst), .accept(accept), .ld_leak(ld_leak),
        .add_en(add_en), .fire_en(fire_en), .commit(commit),
        .sensors(sensors), .nrn_idx(nrn_idx), .src_idx(src_idx),
        .weight(weight), .leak(leak), .thresh(thresh), .act(act)
    );

    assign spikes = act;
    assign motor  = act[N_MOTOR-1:0];

endmodule

// File: rtl/ifn_neurocontroller_checker.sv
module ifn_neurocontroller_checker #(
    parameter int N_NET = 10,
    parameter int N_SRC = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             done,
    input logic [N_NET-1:0] spikes
);

    localparam int LAT = N_NET * (N_SRC + 2) + 1;

    logic        run_q;
    logic [15:0] cnt_q;

    // Independent step tracker: opened by an idle start, closed by done
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (!run_q && start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            if (done)
                run_q <= 1'b0;
            cnt_q <= cnt_q + 16'd1;
        end
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_spikes_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(spikes));

    assert_step_latency_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_q && int'(cnt_q) == LAT));

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (spikes == '0 && !done));

endmodule

bind ifn_neurocontroller ifn_neurocontroller_checker #(
    .N_NET(N_NET), .N_SRC(N_SRC)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .done(done), .spikes(spikes)
);

// File: tb/ifn_neurocontroller_test.sv
module ifn_neurocontroller_test;

    localparam int NN   = 10;
    localparam int NS   = 5;
    localparam int NSRC = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [NS-1:0] sensors = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = '0;
    logic [3:0]  wr_dst = '0;
    logic [3:0]  wr_src = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  motor;
    logic [NN-1:0] spikes;
    logic        done;

    always #10 clk = ~clk;

    ifn_neurocontroller uut (
        .clk(clk), .rst(rst), .start(start), .sensors(sensors),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_dst(wr_dst), .wr_src(wr_src),
        .wr_data(wr_data), .motor(motor), .spikes(spikes), .done(done)
    );

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [NN-1:0] exp;
        string         tag;
    } item_t;
    item_t sb[$];

    int mW [NN][NSRC];
    int mL [NN];
    int mT [NN];
    int mV [NN];
    logic [NN-1:0] mA = '0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic int clamp16(input int x);
        if (x > 32767)  return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    // Reference step built from the requirements
    function automatic void model_step(input logic [NS-1:0] s);
        logic [NN-1:0] na;
        int acc;
        bit on;
        na = '0;
        for (int i = 0; i < NN; i++) begin
            acc = (mV[i] * mL[i]) >>> 8;
            for (int j = 0; j < NSRC; j++) begin
                on = (j < NS) ? s[j] : mA[j-NS];
                if (on) acc = clamp16(acc + mW[i][j]);
            end
            if (acc > mT[i]) begin
                na[i] = 1'b1;
                mV[i] = 0;
            end else begin
                mV[i] = acc;
            end
        end
        mA = na;
    endfunction

    task automatic wr(input int kind, input int dst, input int src, input int data, input bit apply);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_kind = 2'(kind);
        wr_dst  = 4'(dst);
        wr_src  = 4'(src);
        wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
        if (apply) begin
            if (kind == 0) mW[dst][src] = int'($signed(wr_data[7:0]));
            if (kind == 1) mL[dst] = int'(wr_data[7:0]);
            if (kind == 2) mT[dst] = int'($signed(wr_data));
        end
    endtask

    task automatic step(input logic [NS-1:0] s, input string tag);
        @(negedge clk);
        sensors = s;
        start   = 1'b1;
        model_step(s);
        sb.push_back('{mA, tag});
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
    endtask

    // Step with a stray start, a threshold write and a sensor change mid-step
    task automatic step_disturbed(input logic [NS-1:0] s, input string tag);
        @(negedge clk);
        sensors = s;
        start   = 1'b1;
        model_step(s);
        sb.push_back('{mA, tag});
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        start   = 1'b1;
        sensors = ~s;
        wr_en   = 1'b1;
        wr_kind = 2'd2;
        wr_dst  = 4'd0;
        wr_data = 16'h7fff;
        @(negedge clk);
        start = 1'b0;
        wr_en = 1'b0;
        while (!done) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7 R11 unexpected done", 1, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(spikes == it.exp, {it.tag, " spikes"}, int'(spikes), int'(it.exp));
                check(motor == it.exp[3:0], {it.tag, " R8 motor"}, int'(motor), int'(it.exp[3:0]));
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            check(1'b0, "watchdog", cyc, 0);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < NN; i++) begin
            mL[i] = 0; mT[i] = 0; mV[i] = 0;
            for (int j = 0; j < NSRC; j++) mW[i][j] = 0;
        end
        repeat (3) @(negedge clk);
        check(spikes == '0, "R10 reset spikes", int'(spikes), 0);
        check(motor == '0, "R10 reset motor", int'(motor), 0);
        check(!done, "R10 reset done", int'(done), 0);
        rst = 1'b0;

        step(5'b00000, "R1 blank network");

        // R3: equality does not fire, one above does
        wr(0, 0, 0, 10, 1);
        wr(2, 0, 0, 10, 1);
        step(5'b00001, "R3 equal threshold");
        wr(2, 0, 0, 9, 1);
        step(5'b00001, "R3 above threshold");

        // R2: half leak integration
        wr(1, 1, 0, 128, 1);
        wr(0, 1, 1, 40, 1);
        wr(2, 1, 0, 70, 1);
        for (int k = 0; k < 5; k++) step(5'b00010, "R2 leak integration");

        // R4: self loop refires with no refractory gap
        wr(0, 2, 2, 50, 1);
        wr(0, 2, 7, 50, 1);
        wr(2, 2, 0, 40, 1);
        step(5'b00100, "R4 first spike");
        step(5'b00100, "R4 refire");
        step(5'b00000, "R4 self sustained");

        // R6: neuron 3 follows neuron 6 one step later
        wr(0, 6, 3, 100, 1);
        wr(2, 6, 0, 50, 1);
        wr(0, 3, 11, 60, 1);
        wr(2, 3, 0, 30, 1);
        step(5'b01000, "R6 source fires");
        step(5'b00000, "R6 follower fires");
        step(5'b00000, "R6 chain settles");

        // R9 R11 R6: disturbances during a running step are dropped
        step_disturbed(5'b00001, "R9 R11 R6 busy disturbance");
        step(5'b00001, "R9 threshold kept");
        wr(3, 0, 0, 16'h7fff, 0);
        step(5'b00001, "R9 unused kind");

        // R5: saturation in both directions
        for (int s = 0; s < NS; s++) wr(0, 4, s, 127, 1);
        wr(1, 4, 0, 255, 1);
        wr(2, 4, 0, 32766, 1);
        for (int s = 0; s < 4; s++) wr(0, 5, s, -128, 1);
        wr(0, 5, 4, 127, 1);
        wr(1, 5, 0, 255, 1);
        wr(2, 5, 0, 0, 1);
        for (int k = 0; k < 90; k++) step(5'b01111, "R5 saturation");
        for (int k = 0; k < 8; k++) step(5'b10000, "R5 recovery");

        // R1 R8: random configuration and sensors
        for (int i = 0; i < NN; i++) begin
            for (int j = 0; j < NSRC; j++) wr(0, i, j, int'($urandom_range(0, 255)) - 128, 1);
            wr(1, i, 0, int'($urandom_range(0, 255)), 1);
            wr(2, i, 0, int'($urandom_range(0, 600)) - 200, 1);
        end
        for (int k = 0; k < 30; k++) step(NS'($urandom), "R1 R8 random");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R7 all steps reported", sb.size(), 0);
        finish_run();
    end

endmodule